// File: doc/BRIEF.md
# SPI Mode-0 Slave with Shift-Register Preload

This block is an SPI slave for clock mode 0. SCLK idles low, MOSI is captured on the rising edge and MISO moves on the falling edge. Frames are 8 bits, MSB first. The three pin inputs pass through a synchroniser into the system clock, and all decisions are made there. Transfers are full duplex: every byte clocked in by the master clocks one byte out on MISO. The master may run several bytes back to back while select stays low.

In mode 0 the first outgoing bit must already sit on MISO before the first SCLK edge of a byte. For this reason the outgoing byte is fixed at a load instant, which is either the select falling or the falling edge that closes the previous byte. A transmit FIFO feeds these loads. A second write port, the direct port, can place a byte in the shift register. It does so immediately when the slave is waiting with an empty filler byte. Otherwise it holds the byte as a pending entry for the next load.

Received bytes go into a receive FIFO that is read through a valid/ready handshake. An interrupt level stays high while that FIFO holds data. Two sticky error flags record a dropped receive byte and a byte sent as filler. A write-one-to-clear input resets the flags.

Top module: `spi_preload_slave`

## Requirements
- R1: While the synchronised select is high, miso_oe is 0 and miso is 0. While select is low, miso_oe is 1.
- R2: On each SCLK rising edge MOSI is shifted in, MSB first. The byte is pushed into the receive FIFO on the 8th rising edge of a byte.
- R3: From a load until the first falling edge, miso shows bit 7 of the loaded byte. Each of the next seven falling edges moves miso to the next lower bit.
- R4: A load takes place on the select falling edge and on the falling edge that follows the 8th rising edge. Its source is chosen in this order: first the transmit FIFO head, which is then removed; then the pending direct byte; then 0x00.
- R5: A transmit FIFO write accepted in or after the cycle of a load is not used for that load. It waits for the next load.
- R6: A direct write while select is low, between bytes (no rising edge yet), with a filler 0x00 loaded, replaces the shift register at once. Any other direct write becomes the single pending entry, and a newer write replaces an older one.
- R7: Select rising partway through a byte discards the partial byte. Nothing is pushed and the bit count restarts.
- R8: irq and rx_valid are 1 exactly when the receive FIFO is not empty. rx_data is the oldest byte, and a byte is removed when rx_valid and rx_ready are both 1.
- R9: Both FIFOs hold 4 bytes. tx_ready is 0 and tx_empty is 0 when the transmit FIFO holds 4. tx_empty is 1 when it holds none. rx_full is 1 when the receive FIFO holds 4.
- R10: A received byte arriving at a full receive FIFO with no read in the same cycle is dropped and sets rx_ovf. If a read happens in that same cycle, the byte is stored.
- R11: tx_unf is set when the first rising edge of a byte occurs while the loaded byte is the 0x00 filler.
- R12: clr_flags bit 0 clears rx_ovf and bit 1 clears tx_unf. A set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | SPI clock from master (asynchronous) |
| mosi | input | 1 | Serial data from master |
| ss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for the miso pad |
| tx_data | input | 8 | Transmit FIFO write data |
| tx_valid | input | 1 | Transmit FIFO write request |
| tx_ready | output | 1 | Transmit FIFO can accept |
| pre_data | input | 8 | Direct shift-register write data |
| pre_valid | input | 1 | Direct write strobe |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_ready | input | 1 | Consume the oldest received byte |
| irq | output | 1 | Level interrupt, receive data present |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_ovf | output | 1 | Sticky receive overflow |
| tx_unf | output | 1 | Sticky transmit underflow |
| clr_flags | input | 2 | Write-one-to-clear: bit 0 rx_ovf, bit 1 tx_unf |

## Verification
Two pairs of functions can meet in one cycle. The first pair is the push of a completed byte into a full receive FIFO and a read of that FIFO. The bench fills the FIFO and then sweeps a one-cycle rx_ready pulse across the cycles around the final SCLK rise of a fifth byte, so that the read lands before, on, and after the push. A behavioural queue model decides each outcome, stored or overflowed. The second pair is a transmit FIFO write and a load. The bench places writes just after the select falls and judges them by the byte the master actually receives.

// File: rtl/spi_preload_slave.sv
module spi_preload_slave #(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              ss_n,
  output logic              miso,
  output logic              miso_oe,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] pre_data,
  input  logic              pre_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              irq,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_ovf,
  output logic              tx_unf,
  input  logic [1:0]        clr_flags
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int CW = AW + 1;
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(FIFO_DEPTH);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);
  localparam logic [BW-1:0] DONE_CNT = BW'(DATA_W);

  logic [SYNC_STAGES-1:0] sclk_p, mosi_p, ss_p;
  logic sclk_d, ss_d;
  logic sclk_s, mosi_s, ss_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      mosi_p <= '0;
      ss_p   <= '1;
      sclk_d <= 1'b0;
      ss_d   <= 1'b1;
    end else begin
      sclk_p <= SYNC_STAGES'({sclk_p, sclk});
      mosi_p <= SYNC_STAGES'({mosi_p, mosi});
      ss_p   <= SYNC_STAGES'({ss_p, ss_n});
      sclk_d <= sclk_s;
      ss_d   <= ss_s;
    end
  end

  assign sclk_s = sclk_p[SYNC_STAGES-1];
  assign mosi_s = mosi_p[SYNC_STAGES-1];
  assign ss_s   = ss_p[SYNC_STAGES-1];

  logic active, ss_fall, rise, fall;
  assign active  = !ss_s;
  assign ss_fall = active && ss_d;
  assign rise    = active && !ss_fall && sclk_s && !sclk_d;
  assign fall    = active && !ss_fall && !sclk_s && sclk_d;

  logic [BW-1:0]     bit_cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh, pend_q;
  logic              tx_filler, pend_v;

  logic [DATA_W-1:0] tx_mem [FIFO_DEPTH];
  logic [AW-1:0]     tx_wp, tx_rp;
  logic [CW-1:0]     tx_cnt;
  logic [DATA_W-1:0] rx_mem [FIFO_DEPTH];
  logic [AW-1:0]     rx_wp, rx_rp;
  logic [CW-1:0]     rx_cnt;

  logic load, tx_push, tx_pop, rx_push, rx_pop, rx_accept, direct_now;
  logic [DATA_W-1:0] rx_byte;

  assign load       = ss_fall || (fall && bit_cnt == DONE_CNT);
  assign tx_ready   = tx_cnt != FULL_CNT;
  assign tx_empty   = tx_cnt == '0;
  assign tx_push    = tx_valid && tx_ready;
  assign tx_pop     = load && !tx_empty;
  assign direct_now = pre_valid && active && !load && !rise && bit_cnt == '0 && tx_filler;

  assign rx_byte    = {rx_sh[DATA_W-2:0], mosi_s};
  assign rx_push    = rise && bit_cnt == LAST_BIT;
  assign rx_valid   = rx_cnt != '0;
  assign rx_full    = rx_cnt == FULL_CNT;
  assign rx_pop     = rx_valid && rx_ready;
  assign rx_accept  = rx_push && (!rx_full || rx_pop);
  assign rx_data    = rx_mem[rx_rp];
  assign irq        = rx_valid;

  assign miso_oe = active;
  assign miso    = active && tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (!active || ss_fall) begin
      bit_cnt <= '0;
    end else if (rise && bit_cnt < DONE_CNT) begin
      rx_sh   <= rx_byte;
      bit_cnt <= bit_cnt + 1'b1;
    end else if (load) begin
      bit_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh     <= '0;
      tx_filler <= 1'b1;
      pend_v    <= 1'b0;
      pend_q    <= '0;
    end else begin
      if (load) begin
        if (!tx_empty) begin
          tx_sh     <= tx_mem[tx_rp];
          tx_filler <= 1'b0;
        end else if (pre_valid || pend_v) begin
          tx_sh     <= pre_valid ? pre_data : pend_q;
          tx_filler <= 1'b0;
        end else begin
          tx_sh     <= '0;
          tx_filler <= 1'b1;
        end
      end else if (direct_now) begin
        tx_sh     <= pre_data;
        tx_filler <= 1'b0;
      end else if (fall && bit_cnt != '0 && bit_cnt < DONE_CNT) begin
        tx_sh <= tx_sh << 1;
      end

      if (load && tx_empty) begin
        pend_v <= 1'b0;
      end else if (pre_valid && !direct_now) begin
        pend_v <= 1'b1;
        pend_q <= pre_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_accept) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)    rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_accept) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push)   tx_mem[tx_wp] <= tx_data;
    if (rx_accept) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ovf <= 1'b0;
      tx_unf <= 1'b0;
    end else begin
      rx_ovf <= (rx_push && !rx_accept) || (rx_ovf && !clr_flags[0]);
      tx_unf <= (rise && bit_cnt == '0 && tx_filler) || (tx_unf && !clr_flags[1]);
    end
  end
endmodule

// File: rtl/spi_preload_slave_chk.sv
module spi_preload_slave_chk #(
  parameter int DATA_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         miso,
  input logic                         miso_oe,
  input logic                         irq,
  input logic                         rx_valid,
  input logic                         rx_ready,
  input logic                         rx_full,
  input logic                         tx_ready,
  input logic                         tx_empty,
  input logic                         rx_ovf,
  input logic                         tx_unf,
  input logic [1:0]                   clr_flags,
  input logic [$clog2(DATA_W+1)-1:0]  bit_cnt
);
  timeunit 1ns;
  timeprecision 1ps;

  assert_miso_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso);

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= ($clog2(DATA_W+1))'(DATA_W));

  assert_cnt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |=> bit_cnt == '0);

  assert_irq_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> irq);

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);

  assert_empty_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_ready);

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf && !clr_flags[0] |=> rx_ovf);

  assert_unf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_unf && !clr_flags[1] |=> tx_unf);
endmodule

bind spi_preload_slave spi_preload_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .miso(miso), .miso_oe(miso_oe), .irq(irq),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_full(rx_full),
  .tx_ready(tx_ready), .tx_empty(tx_empty), .rx_ovf(rx_ovf), .tx_unf(tx_unf),
  .clr_flags(clr_flags), .bit_cnt(bit_cnt)
);

// File: tb/test_spi_preload_slave.sv
module test_spi_preload_slave;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic [7:0] tx_data = '0, pre_data = '0;
  logic tx_valid = 1'b0, pre_valid = 1'b0, rx_ready = 1'b0;
  logic [1:0] clr_flags = '0;
  logic miso, miso_oe, tx_ready, rx_valid, irq, tx_empty, rx_full, rx_ovf, tx_unf;
  logic [7:0] rx_data;

  always #2.5 clk = ~clk;

  spi_preload_slave i_spi_preload_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
    .miso(miso), .miso_oe(miso_oe), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .pre_data(pre_data), .pre_valid(pre_valid),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq),
    .tx_empty(tx_empty), .rx_full(rx_full), .rx_ovf(rx_ovf), .tx_unf(tx_unf),
    .clr_flags(clr_flags)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // behavioural reference
  bit qs[$], qm[$], qss[$];
  logic [7:0] mtx[$], mrx[$];
  logic [7:0] m_sh, m_rx, m_pend_d;
  bit m_pend, m_fill, m_ovf, m_unf;
  int m_cnt;
  bit s_sclk, d_sclk, s_ss, d_ss, s_mosi, act, sf, r, f, ld, pop, dir, ovf_set, unf_set, was_empty;

  always @(posedge clk) begin
    if (!rst_n) begin
      qs = '{0, 0, 0}; qm = '{0, 0, 0}; qss = '{1, 1, 1};
      mtx.delete(); mrx.delete();
      m_sh = '0; m_rx = '0; m_pend_d = '0;
      m_pend = 0; m_fill = 1; m_ovf = 0; m_unf = 0; m_cnt = 0;
    end else begin
      s_sclk = qs[1]; d_sclk = qs[0]; s_ss = qss[1]; d_ss = qss[0]; s_mosi = qm[1];
      act = !s_ss; sf = act && d_ss;
      r = act && !sf && s_sclk && !d_sclk;
      f = act && !sf && !s_sclk && d_sclk;
      ld = sf || (f && m_cnt == 8);
      pop = rx_ready && mrx.size() > 0;
      dir = pre_valid && act && !ld && !r && m_cnt == 0 && m_fill;
      unf_set = r && m_cnt == 0 && m_fill;
      ovf_set = 0;
      was_empty = mtx.size() == 0;
      if (pop) void'(mrx.pop_front());
      if (r && m_cnt == 7) begin
        if (mrx.size() < 4) mrx.push_back({m_rx[6:0], s_mosi});
        else ovf_set = 1;
      end
      if (ld) begin
        if (!was_empty) begin m_sh = mtx.pop_front(); m_fill = 0; end
        else if (pre_valid) begin m_sh = pre_data; m_fill = 0; end
        else if (m_pend) begin m_sh = m_pend_d; m_fill = 0; end
        else begin m_sh = 8'h00; m_fill = 1; end
        if (was_empty) m_pend = 0;
      end else if (dir) begin
        m_sh = pre_data; m_fill = 0;
      end else if (f && m_cnt >= 1 && m_cnt <= 7) begin
        m_sh = m_sh << 1;
      end
      if (pre_valid && !dir && !(ld && was_empty)) begin m_pend = 1; m_pend_d = pre_data; end
      if (!act || sf) m_cnt = 0;
      else if (r && m_cnt < 8) begin m_rx = {m_rx[6:0], s_mosi}; m_cnt++; end
      else if (ld) m_cnt = 0;
      if (tx_valid && mtx.size() < 4) mtx.push_back(tx_data);
      m_ovf = ovf_set || (m_ovf && !clr_flags[0]);
      m_unf = unf_set || (m_unf && !clr_flags[1]);
      void'(qs.pop_front()); qs.push_back(sclk);
      void'(qm.pop_front()); qm.push_back(mosi);
      void'(qss.pop_front()); qss.push_back(ss_n);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 miso_oe", miso_oe, !qss[1]);
      chk("R3 miso", miso, !qss[1] && m_sh[7]);
      chk("R8 irq", irq, mrx.size() > 0);
      chk("R8 rx_valid", rx_valid, mrx.size() > 0);
      if (mrx.size() > 0) chk("R8 rx_data", rx_data, mrx[0]);
      chk("R9 tx_ready", tx_ready, mtx.size() < 4);
      chk("R9 tx_empty", tx_empty, mtx.size() == 0);
      chk("R9 rx_full", rx_full, mrx.size() == 4);
      chk("R10 rx_ovf", rx_ovf, m_ovf);
      chk("R11 tx_unf", tx_unf, m_unf);
    end
  end

  task automatic xfer(input logic [7:0] mo, input int pop_at, output logic [7:0] mi);
    mi = '0;
    for (int i = 7; i >= 0; i--) begin
      mosi = mo[i];
      repeat (H) @(negedge clk);
      mi[i] = miso;
      sclk = 1'b1;
      if (i == 0 && pop_at >= 0) begin
        repeat (pop_at) @(negedge clk);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        repeat (H - pop_at - 1) @(negedge clk);
      end else begin
        repeat (H) @(negedge clk);
      end
      sclk = 1'b0;
    end
  endtask

  task automatic xchk(input logic [7:0] mo, input logic [7:0] exp, input string req);
    logic [7:0] got;
    xfer(mo, -1, got);
    chk(req, got, exp);
  endtask

  task automatic wr_tx(input logic [7:0] d);
    tx_data = d; tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic wr_pre(input logic [7:0] d);
    pre_data = d; pre_valid = 1'b1; @(negedge clk); pre_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] exp, input string req);
    chk(req, rx_valid, 1'b1);
    chk(req, rx_data, exp);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic drain();
    rx_ready = 1'b1;
    while (rx_valid) @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic clear();
    clr_flags = 2'b11; @(negedge clk); clr_flags = 2'b00;
  endtask

  task automatic sel(input logic v);
    ss_n = v; repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset oe", miso_oe, 1'b0);
    chk("R8 reset irq", irq, 1'b0);
    chk("R9 reset tx_empty", tx_empty, 1'b1);
    chk("R10 reset ovf", rx_ovf, 1'b0);

    // R11: nothing to send gives filler and underflow; R2 byte capture
    sel(1'b0);
    xchk(8'hC3, 8'h00, "R4 filler byte");
    sel(1'b1);
    chk("R11 unf set", tx_unf, 1'b1);
    rd(8'hC3, "R2 rx byte");
    clear();
    chk("R12 unf cleared", tx_unf, 1'b0);

    // preload then FIFO write after load: R4 and R5
    wr_pre(8'h55);
    ss_n = 1'b0; repeat (5) @(negedge clk);
    wr_tx(8'h77);
    xchk(8'h01, 8'h55, "R5 preload first");
    xchk(8'h02, 8'h77, "R4 fifo second");
    sel(1'b1);
    chk("R11 no unf", tx_unf, 1'b0);
    rd(8'h01, "R2 first"); rd(8'h02, "R2 second");

    // late FIFO write with filler loaded
    ss_n = 1'b0; repeat (5) @(negedge clk);
    wr_tx(8'h3C);
    xchk(8'h10, 8'h00, "R5 late write unused");
    xchk(8'h11, 8'h3C, "R5 late write next");
    sel(1'b1);
    chk("R11 unf late", tx_unf, 1'b1);
    drain(); clear();

    // direct write in gap replaces filler: R6
    ss_n = 1'b0; repeat (5) @(negedge clk);
    wr_pre(8'h9A);
    xchk(8'h20, 8'h9A, "R6 direct to shift");
    sel(1'b1);
    chk("R6 no unf", tx_unf, 1'b0);
    wr_pre(8'h11); wr_pre(8'h22); wr_tx(8'h66);
    sel(1'b0);
    xchk(8'h21, 8'h66, "R4 fifo over pending");
    xchk(8'h22, 8'h22, "R6 newest pending");
    xchk(8'h23, 8'h00, "R4 nothing left");
    sel(1'b1);
    drain(); clear();

    // abort partway: R7
    ss_n = 1'b0; repeat (H) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1; repeat (H) @(negedge clk); sclk = 1'b1; repeat (H) @(negedge clk); sclk = 1'b0;
    end
    sel(1'b1);
    chk("R7 nothing pushed", irq, 1'b0);
    sel(1'b0);
    xfer(8'h5A, -1, got);
    sel(1'b1);
    rd(8'h5A, "R7 clean restart");
    clear();

    // TX depth and RX overflow: R9 R10
    for (int i = 0; i < 5; i++) wr_tx(8'hB0 + 8'(i));
    chk("R9 tx full", tx_ready, 1'b0);
    sel(1'b0);
    for (int i = 0; i < 5; i++) xchk(8'hA0 + 8'(i), (i < 4) ? 8'hB0 + 8'(i) : 8'h00, "R9 tx depth order");
    sel(1'b1);
    chk("R9 rx full", rx_full, 1'b1);
    chk("R10 ovf set", rx_ovf, 1'b1);
    for (int i = 0; i < 4; i++) rd(8'hA0 + 8'(i), "R10 kept bytes");
    clr_flags = 2'b01; @(negedge clk); clr_flags = 2'b00;
    chk("R12 ovf cleared", rx_ovf, 1'b0);
    chk("R12 unf kept", tx_unf, 1'b1);
    clear();

    // push at full against read, swept across cycles: R10
    for (int k = 0; k < 5; k++) begin
      sel(1'b0);
      for (int i = 0; i < 4; i++) xfer(8'hE0 + 8'(i), -1, got);
      xfer(8'hF0 + 8'(k), k, got);
      sel(1'b1);
      chk("R10 sweep ovf", rx_ovf, k > 2);
      drain(); clear();
    end

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule